// File: doc/BRIEF.md
# Thread Context Suspend/Resume Controller

This block sits beside one hardware thread context and parks or revives it. A halt request while the context runs clears its run flag and saves the address the thread should pick up from, which is the upcoming (next) program counter rather than the one currently executing. A restore request while the context is parked rebuilds a three-entry program-counter chain from the saved address, at strides of one and two instruction words (4 and 8 bytes), and sets the run flag again.

The saved address lives in a restart register that software may also overwrite through a simple write strobe, for example to redirect a parked thread before reviving it. The register is always visible on a readback output. Fetch, correction of the saved address for branch delay slots, and choosing among several contexts are handled elsewhere.

Top module: `tcx_ctrl_top`

## Requirements
- R1: After reset the run flag is 0 and the restart register and all three chain outputs are 0.
- R2: When the run flag is 1 and a halt is requested, the run flag is 0 after the next clock edge and the restart register holds the next-PC input sampled at that edge.
- R3: A halt request while the run flag is 0 changes neither the run flag nor the restart register.
- R4: A restore request while the run flag is 0 and no halt is requested loads, at the next edge, the chain with the restart value, that value plus 4 and that value plus 8 (each modulo 2 to the power of the address width) and sets the run flag to 1.
- R5: A restore request while the run flag is 1 leaves the chain and the run flag unchanged; without an effective restore the chain holds its value.
- R6: When halt and restore are requested in the same cycle the restore is dropped: the chain keeps its value, and the run flag falls if it was 1 or stays 0 if it was 0.
- R7: A software write updates the restart register at the next edge unless an effective halt (run flag 1 and halt requested) occurs in that cycle, in which case the captured next PC wins.
- R8: A software write in the same cycle as an effective restore loads the chain from the restart value held before that edge, while the register takes the new written value.
- R9: The readback output always shows the restart register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| haltReq | input | 1 | Request to suspend the context |
| restoreReq | input | 1 | Request to resume the context |
| nextPc | input | ADDR_W | Next program counter of the running context |
| swWrEn | input | 1 | Software write strobe for the restart register |
| swWrData | input | ADDR_W | Software write value |
| active | output | 1 | Context run flag |
| pcOut | output | ADDR_W | Chain entry 0 (program counter) |
| npcOut | output | ADDR_W | Chain entry 1 (next program counter) |
| nnpcOut | output | ADDR_W | Chain entry 2 (next-next program counter) |
| restartRd | output | ADDR_W | Restart register readback |

## Verification
The functions that can meet in one cycle are the halt capture and the software write to the restart register, and the restore reload with that same write. The bench drives halt plus write while running and checks that the next PC, not the written value, lands in the register; it drives restore plus write while parked and checks that the chain carries the older saved address while the readback shows the new one. Halt together with restore is provoked in both run states and judged by the chain staying put.

// File: rtl/tcx_pkg.sv
package tcx_pkg;
  localparam int unsigned INSTR_BYTES = 4;
  localparam int unsigned CHAIN_LEN   = 3;

  typedef struct packed {
    logic captureNext; // save next PC into the restart register
    logic swLoad;      // software value into the restart register
    logic reloadChain; // rebuild the PC chain from the restart register
  } tcx_strobe_t;
endpackage

// File: rtl/tcx_ctrl_fsm.sv
module tcx_ctrl_fsm
  import tcx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltReq,
  input  logic        restoreReq,
  input  logic        swWrEn,
  output logic        active,
  output tcx_strobe_t strobe
);
  logic activeQ;
  logic haltHit;
  logic restoreHit;

  // Halt only matters while running; any halt request drops a restore.
  always_comb begin
    haltHit    = activeQ && haltReq;
    restoreHit = !activeQ && restoreReq && !haltReq;
    strobe.captureNext = haltHit;
    strobe.swLoad      = swWrEn && !haltHit;
    strobe.reloadChain = restoreHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
    end else if (haltHit) begin
      activeQ <= 1'b0;
    end else if (restoreHit) begin
      activeQ <= 1'b1;
    end
  end

  assign active = activeQ;

  p_halt_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (active && haltReq) |=> !active);

  p_halt_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!active && haltReq) |=> !active);

  p_restore_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!active && restoreReq && !haltReq) |=> active);

  p_restore_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && restoreReq && !haltReq) |=> active);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.captureNext, strobe.reloadChain}));
endmodule

// File: rtl/tcx_datapath.sv
module tcx_datapath
  import tcx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcx_strobe_t       strobe,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [ADDR_W-1:0] swWrData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] npcOut,
  output logic [ADDR_W-1:0] nnpcOut,
  output logic [ADDR_W-1:0] restartRd
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] restartQ;
  logic [ADDR_W-1:0] chainQ [CHAIN_LEN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restartQ <= '0;
    end else if (strobe.captureNext) begin
      restartQ <= nextPc;
    end else if (strobe.swLoad) begin
      restartQ <= swWrData;
    end
  end

  for (genvar gi = 0; gi < CHAIN_LEN; gi++) begin : g_chain
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(gi) * STEP;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chainQ[gi] <= '0;
      end else if (strobe.reloadChain) begin
        chainQ[gi] <= restartQ + OFFS;
      end
    end
  end

  assign pcOut     = chainQ[0];
  assign npcOut    = chainQ[1];
  assign nnpcOut   = chainQ[2];
  assign restartRd = restartQ;

  p_capture_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureNext |=> (restartRd == $past(nextPc)));

  p_reload_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reloadChain |=> (pcOut == $past(restartRd)));

  p_reload_stride_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reloadChain |=> (npcOut == pcOut + 4) && (nnpcOut == pcOut + 8));

  p_chain_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reloadChain |=> $stable(pcOut) && $stable(npcOut) && $stable(nnpcOut));

  p_sw_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swLoad && !strobe.captureNext) |=> (restartRd == $past(swWrData)));
endmodule

// File: rtl/tcx_ctrl_top.sv
module tcx_ctrl_top
  import tcx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  input  logic              restoreReq,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic              swWrEn,
  input  logic [ADDR_W-1:0] swWrData,
  output logic              active,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] npcOut,
  output logic [ADDR_W-1:0] nnpcOut,
  output logic [ADDR_W-1:0] restartRd
);
  tcx_strobe_t strobe;

  tcx_ctrl_fsm ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .haltReq    (haltReq),
    .restoreReq (restoreReq),
    .swWrEn     (swWrEn),
    .active     (active),
    .strobe     (strobe)
  );

  tcx_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .nextPc    (nextPc),
    .swWrData  (swWrData),
    .pcOut     (pcOut),
    .npcOut    (npcOut),
    .nnpcOut   (nnpcOut),
    .restartRd (restartRd)
  );

  p_readback_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !haltReq && !swWrEn) |=> $stable(restartRd));
endmodule

// File: tb/tcx_ctrl_top_tb.sv
module tcx_ctrl_top_tb_top;
  localparam int AW = 32;

  typedef struct packed {
    logic          halt;
    logic          restore;
    logic          wr;
    logic [AW-1:0] wrData;
    logic [AW-1:0] nxt;
    logic          expAct;
    logic [AW-1:0] expPc;
    logic [AW-1:0] expNpc;
    logic [AW-1:0] expNnpc;
    logic [AW-1:0] expRst;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 32'h100, 32'h50, 1'b0, 32'h0, 32'h0, 32'h0, 32'h100},
    '{1'b0, 1'b1, 1'b0, 32'h0, 32'h50, 1'b1, 32'h100, 32'h104, 32'h108, 32'h100},
    '{1'b0, 1'b1, 1'b1, 32'h200, 32'h50, 1'b1, 32'h100, 32'h104, 32'h108, 32'h200},
    '{1'b1, 1'b0, 1'b1, 32'h999, 32'h3C, 1'b0, 32'h100, 32'h104, 32'h108, 32'h3C},
    '{1'b1, 1'b0, 1'b0, 32'h0, 32'h77, 1'b0, 32'h100, 32'h104, 32'h108, 32'h3C},
    '{1'b0, 1'b1, 1'b1, 32'h400, 32'h0, 1'b1, 32'h3C, 32'h40, 32'h44, 32'h400},
    '{1'b1, 1'b1, 1'b0, 32'h0, 32'h88, 1'b0, 32'h3C, 32'h40, 32'h44, 32'h88},
    '{1'b0, 1'b0, 1'b1, 32'hFFFF_FFFC, 32'h0, 1'b0, 32'h3C, 32'h40, 32'h44, 32'hFFFF_FFFC},
    '{1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFC, 32'h0, 32'h4, 32'hFFFF_FFFC},
    '{1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFC, 32'h0, 32'h4, 32'hFFFF_FFFC},
    '{1'b1, 1'b0, 1'b0, 32'h0, 32'h500, 1'b0, 32'hFFFF_FFFC, 32'h0, 32'h4, 32'h500},
    '{1'b1, 1'b1, 1'b0, 32'h0, 32'h600, 1'b0, 32'hFFFF_FFFC, 32'h0, 32'h4, 32'h500}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          haltReq = 1'b0;
  logic          restoreReq = 1'b0;
  logic [AW-1:0] nextPc = '0;
  logic          swWrEn = 1'b0;
  logic [AW-1:0] swWrData = '0;
  logic          active;
  logic [AW-1:0] pcOut, npcOut, nnpcOut, restartRd;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tcx_ctrl_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .restoreReq(restoreReq),
    .nextPc(nextPc), .swWrEn(swWrEn), .swWrData(swWrData), .active(active),
    .pcOut(pcOut), .npcOut(npcOut), .nnpcOut(nnpcOut), .restartRd(restartRd)
  );

  task automatic check(input string what, input string req,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string rowTag(input int i);
    case (i)
      0:  return "R7";
      1:  return "R4";
      2:  return "R5";
      3:  return "R2";
      4:  return "R3";
      5:  return "R8";
      6:  return "R6";
      7:  return "R9";
      8:  return "R4";
      9:  return "R5";
      10: return "R2";
      default: return "R6";
    endcase
  endfunction

  task automatic checkAll(input string req, input vec_t v);
    check("active", req, AW'(active), AW'(v.expAct));
    check("pc", req, pcOut, v.expPc);
    check("npc", req, npcOut, v.expNpc);
    check("nnpc", req, nnpcOut, v.expNnpc);
    check("restart", req, restartRd, v.expRst);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    vec_t zeroV;
    zeroV = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    checkAll("R1", zeroV);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      haltReq    = VECS[i].halt;
      restoreReq = VECS[i].restore;
      swWrEn     = VECS[i].wr;
      swWrData   = VECS[i].wrData;
      nextPc     = VECS[i].nxt;
      @(negedge clk);
      haltReq = 1'b0; restoreReq = 1'b0; swWrEn = 1'b0;
      checkAll(rowTag(i), VECS[i]);
    end
    // R9: readback follows a plain write with no other activity
    swWrEn = 1'b1; swWrData = 32'h1234_5678;
    @(negedge clk);
    swWrEn = 1'b0;
    check("readback", "R9", restartRd, 32'h1234_5678);
    // R1: reset in mid-run clears everything
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R1", zeroV);
    rstN = 1'b1;
    finished = 1'b1;
    finishRun();
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end
endmodule